// File: doc/BRIEF.md
# Programmable Reload Down-Counter Timer

This block is a 16-bit down-counter with an 8-bit control register, a 16-bit reload register and a count readback. All of them sit on a small synchronous register bus. Each qualified tick of the chosen count source lowers the counter by one. The counter reaches end of count when a tick arrives while it holds 1 or 0. At that point a sticky end-of-count flag is raised and drives the interrupt output.

There are four count sources. The first is the system clock through a prescaler that divides by 4, 16, 64 or 256. The second is a tick input from a real-time clock. The last two are an external event input, counted on its falling edge or on its rising edge. Each asynchronous input passes through a two-flop synchroniser and an edge detector in the system clock domain.

In single-pass mode the timer clears its own enable bit at end of count and stops at zero. In continuous mode it reloads and keeps running. A debug-break input can freeze the prescaler and the counter when the control register asks for it.

Top module: `reload_timer`

## Requirements
- R1: After reset, the control register, reload register, count and flag are all 0, and `irq` is low.
- R2: Register addresses are as follows. Address 0 is control: bits 7:0 are read/write and bits 15:8 read as 0. Address 1 is the 16-bit reload value. Address 2 is the count, which is read-only, so a write there has no effect. Address 3 is status, with the end-of-count flag in bit 0.
- R3: Control bits 4:3 select the prescale ratio: 00 = /4, 01 = /16, 10 = /64, 11 = /256. With the system-clock source (bits 6:5 = 00), the first decrement lands exactly one full ratio of clock edges after the enabling write edge. Later decrements follow at the same spacing.
- R4: When bit 2 (mode) is 0, the timer runs in single pass. On the end-of-count tick the count becomes 0, enable bit 0 clears in the same edge, and no further ticks are counted.
- R5: When bit 2 is 1, the timer runs in continuous mode. On the end-of-count tick the counter takes the reload value, and the enable bit stays set.
- R6: A control write that turns bit 0 from 0 to 1 loads the counter from the reload register only if bit 1 is also written as 1. If bit 1 is 0, counting resumes from the held count. The same write restarts the prescaler.
- R7: Bits 6:5 pick the source: 01 is the rising edge of `rtc_tick`, 10 is the falling edge of `evt_in`, and 11 is the rising edge of `evt_in`. A qualifying edge driven before a clock edge changes the count on the third clock edge. The opposite edge has no effect.
- R8: When bit 7 is 1 and `dbg_break` is high, the count and the prescaler hold. Once the break ends, the next decrement comes a full prescale period later. When bit 7 is 0, `dbg_break` has no effect.
- R9: Each end of count sets the flag, and `irq` follows the flag. The flag stays set until a bus read of address 3 clears it. If both happen in the same cycle, the new end of count wins.
- R10: While the enable bit is 0, the count does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Write qualifier with `bus_sel` |
| bus_rd | input | 1 | Read qualifier with `bus_sel`; a status read clears the flag |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from `bus_addr` |
| rtc_tick | input | 1 | Real-time-clock tick input (asynchronous) |
| evt_in | input | 1 | External event input (asynchronous) |
| dbg_break | input | 1 | Debug break request |
| irq | output | 1 | End-of-count flag |

## Verification
Each result has a fixed due edge. A system-clock decrement is due exactly ratio × n edges after the write edge that enables the timer. An event or tick edge shows up in the count on the third clock edge after the input changes, because of the two synchroniser stages and the edge-detect register. The flag, the cleared enable bit and the reload all land on the same edge as the final decrement.

The bench drives inputs and samples `bus_rdata` at falling clock edges. For each case it checks the count one edge before the due edge, to confirm nothing has happened early, and again on the due edge itself. Hold cases are checked over many edges after the stimulus, before anything else is applied.

// File: rtl/timer_pkg.sv
package timer_pkg;
  typedef enum logic [1:0] {
    SRC_SYS      = 2'b00,
    SRC_RTC      = 2'b01,
    SRC_EVT_FALL = 2'b10,
    SRC_EVT_RISE = 2'b11
  } src_e;

  typedef enum logic [1:0] {
    ADR_CTRL   = 2'd0,
    ADR_RELOAD = 2'd1,
    ADR_COUNT  = 2'd2,
    ADR_STATUS = 2'd3
  } adr_e;

  localparam int CB_EN   = 0;
  localparam int CB_RLD  = 1;
  localparam int CB_CONT = 2;
  localparam int CB_DIV  = 3;
  localparam int CB_SRC  = 5;
  localparam int CB_FRZ  = 7;
  localparam int CTRL_W  = 8;
endpackage

// File: rtl/timer_rst_sync.sv
module timer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_ns = sh_q[1];
endmodule

// File: rtl/timer_in_sync.sv
module timer_in_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic prev
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], din};
  end

  assign lvl  = sh_q[STAGES-1];
  assign prev = sh_q[STAGES];
endmodule

// File: rtl/timer_prescaler.sv
module timer_prescaler #(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       adv,
  input  logic [1:0] ratio,
  output logic       tick
);
  logic [W-1:0] cnt_q, cnt_d, limit;
  logic [31:0]  lim_wide;

  always_comb begin
    lim_wide = (32'd4 << {ratio, 1'b0}) - 32'd1;
    limit    = lim_wide[W-1:0];
    tick     = adv && (cnt_q >= limit);
    cnt_d    = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else if (adv)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/timer_count.sv
module timer_count #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         cont,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] count,
  output logic         eoc
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    eoc   = step && (cnt_q <= W'(1));
    cnt_d = cnt_q;
    if (load)      cnt_d = reload_val;
    else if (eoc)  cnt_d = cont ? reload_val : '0;
    else if (step) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/reload_timer.sv
module reload_timer #(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [1:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             rtc_tick,
  input  logic             evt_in,
  input  logic             dbg_break,
  output logic             irq
);
  import timer_pkg::*;

  localparam int N_IN = 2;

  logic                rst_ns;
  logic [CTRL_W-1:0]   ctrl_q, ctrl_d;
  logic [CNT_W-1:0]    reload_q, reload_d, count_q;
  logic                flag_q, flag_d;
  logic                ctrl_wr, reload_wr, stat_rd, en_start;
  logic                freeze, run, pre_tick, src_pulse, step, eoc;
  logic [N_IN-1:0]     in_raw, in_lvl, in_prev;
  src_e                src;

  timer_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ns(rst_ns));

  assign in_raw = {evt_in, rtc_tick};

  genvar gi;
  generate
    for (gi = 0; gi < N_IN; gi++) begin : g_sync
      timer_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_ns), .din(in_raw[gi]),
        .lvl(in_lvl[gi]), .prev(in_prev[gi])
      );
    end
  endgenerate

  assign ctrl_wr   = bus_sel && bus_wr && (bus_addr == ADR_CTRL);
  assign reload_wr = bus_sel && bus_wr && (bus_addr == ADR_RELOAD);
  assign stat_rd   = bus_sel && bus_rd && (bus_addr == ADR_STATUS);
  assign en_start  = ctrl_wr && bus_wdata[CB_EN] && !ctrl_q[CB_EN];

  assign src    = src_e'(ctrl_q[CB_SRC+1:CB_SRC]);
  assign freeze = dbg_break && ctrl_q[CB_FRZ];
  assign run    = ctrl_q[CB_EN] && !freeze;

  timer_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_ns), .clr(en_start),
    .adv(run && (src == SRC_SYS)),
    .ratio(ctrl_q[CB_DIV+1:CB_DIV]), .tick(pre_tick)
  );

  always_comb begin
    unique case (src)
      SRC_SYS:      src_pulse = pre_tick;
      SRC_RTC:      src_pulse = in_lvl[0] && !in_prev[0];
      SRC_EVT_FALL: src_pulse = !in_lvl[1] && in_prev[1];
      SRC_EVT_RISE: src_pulse = in_lvl[1] && !in_prev[1];
      default:      src_pulse = 1'b0;
    endcase
  end

  assign step = run && src_pulse;

  timer_count #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ns),
    .load(en_start && bus_wdata[CB_RLD]),
    .step(step), .cont(ctrl_q[CB_CONT]),
    .reload_val(reload_q), .count(count_q), .eoc(eoc)
  );

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_wr)                      ctrl_d = bus_wdata[CTRL_W-1:0];
    else if (eoc && !ctrl_q[CB_CONT]) ctrl_d[CB_EN] = 1'b0;
    reload_d = reload_wr ? bus_wdata : reload_q;
    flag_d   = flag_q;
    if (eoc)          flag_d = 1'b1;
    else if (stat_rd) flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      ctrl_q   <= '0;
      reload_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      reload_q <= reload_d;
      flag_q   <= flag_d;
    end
  end

  always_comb begin
    unique case (adr_e'(bus_addr))
      ADR_CTRL:   bus_rdata = {{(CNT_W-CTRL_W){1'b0}}, ctrl_q};
      ADR_RELOAD: bus_rdata = reload_q;
      ADR_COUNT:  bus_rdata = count_q;
      ADR_STATUS: bus_rdata = {{(CNT_W-1){1'b0}}, flag_q};
      default:    bus_rdata = '0;
    endcase
  end

  assign irq = flag_q;
endmodule

// File: rtl/reload_timer_checker.sv
module reload_timer_checker #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [7:0]       ctrl_q,
  input logic [CNT_W-1:0] reload_q,
  input logic [CNT_W-1:0] count_q,
  input logic             flag_q,
  input logic             step,
  input logic             eoc,
  input logic             ctrl_wr,
  input logic             reload_wr,
  input logic             stat_rd,
  input logic             freeze
);
  // R4: single pass stops at zero with enable cleared
  a_r4_single_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q <= CNT_W'(1) && !ctrl_q[2] && !ctrl_wr)
      |=> (!ctrl_q[0] && count_q == '0));

  // R5: continuous mode reloads and stays enabled
  a_r5_cont_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (step && count_q <= CNT_W'(1) && ctrl_q[2] && !ctrl_wr && !reload_wr)
      |=> (ctrl_q[0] && count_q == $past(reload_q)));

  // R8: frozen timer holds its count
  a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !ctrl_wr) |=> $stable(count_q));

  // R9: flag is sticky until a status read
  a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !stat_rd) |=> flag_q);

  // R9: end of count always leaves the flag set
  a_r9_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |=> flag_q);

  // R10: a disabled timer holds its count
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[0] && !ctrl_wr) |=> $stable(count_q));
endmodule

bind reload_timer reload_timer_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_ns), .ctrl_q(ctrl_q), .reload_q(reload_q),
  .count_q(count_q), .flag_q(flag_q), .step(step), .eoc(eoc),
  .ctrl_wr(ctrl_wr), .reload_wr(reload_wr), .stat_rd(stat_rd),
  .freeze(freeze)
);

// File: tb/reload_timer_test.sv
module reload_timer_test;
  logic        clk, rst_n, bus_sel, bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata;
  logic        rtc_tick, evt_in, dbg_break, irq;
  int          n_chk = 0, n_fail = 0;
  logic [15:0] rv;

  reload_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .rtc_tick(rtc_tick), .evt_in(evt_in),
    .dbg_break(dbg_break), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // vector: {continuous, ratio sel[1:0], reload[15:0]}
  localparam int NV = 6;
  localparam logic [18:0] VEC [NV] = '{
    {1'b0, 2'd0, 16'd3}, {1'b0, 2'd1, 16'd2}, {1'b0, 2'd2, 16'd2},
    {1'b0, 2'd3, 16'd1}, {1'b1, 2'd0, 16'd5}, {1'b1, 2'd1, 16'd2}
  };

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic stat_clear();
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = 2'd3;
    @(negedge clk);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wait_edges(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1500000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0;
    bus_wdata = 0; rtc_tick = 0; evt_in = 0; dbg_break = 0;
    wait_edges(3);
    rst_n = 1'b1;
    wait_edges(4);

    // R1 reset state
    peek(2'd0, rv); chk("R1 ctrl", rv, 16'h0);
    peek(2'd1, rv); chk("R1 reload", rv, 16'h0);
    peek(2'd2, rv); chk("R1 count", rv, 16'h0);
    peek(2'd3, rv); chk("R1 status", rv, 16'h0);
    chk("R1 irq", {15'b0, irq}, 16'h0);

    // R2 register map
    bus_write(2'd0, 16'hFFFE);
    peek(2'd0, rv); chk("R2 ctrl upper zero", rv, 16'h00FE);
    bus_write(2'd0, 16'h0000);
    bus_write(2'd1, 16'h1234);
    peek(2'd1, rv); chk("R2 reload readback", rv, 16'h1234);
    bus_write(2'd2, 16'hBEEF);
    peek(2'd2, rv); chk("R2 count read-only", rv, 16'h0);

    // R3 R4 R5 vector table
    for (int v = 0; v < NV; v++) begin
      logic        cont;
      logic [1:0]  rs;
      logic [15:0] rl;
      int          due;
      cont = VEC[v][18]; rs = VEC[v][17:16]; rl = VEC[v][15:0];
      due  = int'(rl) * (4 << (2 * rs));
      bus_write(2'd1, rl);
      stat_clear();
      bus_write(2'd0, {11'b0, rs, cont, 2'b11});
      wait_edges(due - 1);
      peek(2'd2, rv); chk("R3 count before due edge", rv, 16'd1);
      chk("R9 irq low before end", {15'b0, irq}, 16'h0);
      wait_edges(1);
      peek(2'd2, rv);
      if (cont) chk("R5 reloaded count", rv, rl);
      else      chk("R4 count stops at zero", rv, 16'd0);
      peek(2'd0, rv);
      chk("R4 R5 enable bit", {15'b0, rv[0]}, {15'b0, cont});
      chk("R9 irq set", {15'b0, irq}, 16'h1);
      if (!cont) begin
        wait_edges(2 * (4 << (2 * rs)));
        peek(2'd2, rv); chk("R4 stays stopped", rv, 16'd0);
      end
      bus_write(2'd0, 16'h0000);
    end

    // R9 status read clears flag
    peek(2'd3, rv); chk("R9 status bit", rv, 16'h1);
    stat_clear();
    chk("R9 cleared by read", {15'b0, irq}, 16'h0);

    // R6 R10 held count and restart without reload
    bus_write(2'd1, 16'd10);
    bus_write(2'd0, 16'h0003);
    wait_edges(8);
    bus_write(2'd0, 16'h0000);
    peek(2'd2, rv); chk("R6 count at disable", rv, 16'd8);
    wait_edges(20);
    peek(2'd2, rv); chk("R10 disabled holds", rv, 16'd8);
    bus_write(2'd0, 16'h0001);
    wait_edges(3);
    peek(2'd2, rv); chk("R6 no reload keeps count", rv, 16'd8);
    wait_edges(1);
    peek(2'd2, rv); chk("R6 resumes from held count", rv, 16'd7);
    bus_write(2'd0, 16'h0000);

    // R7 event rising edge
    bus_write(2'd1, 16'd4);
    bus_write(2'd0, 16'h0063);
    evt_in = 1'b1;
    wait_edges(2);
    peek(2'd2, rv); chk("R7 rise not yet", rv, 16'd4);
    wait_edges(1);
    peek(2'd2, rv); chk("R7 rise counted", rv, 16'd3);
    evt_in = 1'b0;
    wait_edges(5);
    peek(2'd2, rv); chk("R7 fall ignored in rise mode", rv, 16'd3);
    bus_write(2'd0, 16'h0000);

    // R7 event falling edge
    bus_write(2'd0, 16'h0043);
    evt_in = 1'b1;
    wait_edges(5);
    peek(2'd2, rv); chk("R7 rise ignored in fall mode", rv, 16'd4);
    evt_in = 1'b0;
    wait_edges(2);
    peek(2'd2, rv); chk("R7 fall not yet", rv, 16'd4);
    wait_edges(1);
    peek(2'd2, rv); chk("R7 fall counted", rv, 16'd3);
    bus_write(2'd0, 16'h0000);

    // R7 rtc tick
    bus_write(2'd0, 16'h0023);
    @(negedge clk); rtc_tick = 1'b1;
    @(negedge clk); rtc_tick = 1'b0;
    wait_edges(2);
    peek(2'd2, rv); chk("R7 rtc tick counted", rv, 16'd3);
    bus_write(2'd0, 16'h0000);

    // R8 debug break hold
    dbg_break = 1'b1;
    bus_write(2'd1, 16'd10);
    bus_write(2'd0, 16'h0083);
    wait_edges(40);
    peek(2'd2, rv); chk("R8 frozen count", rv, 16'd10);
    dbg_break = 1'b0;
    wait_edges(3);
    peek(2'd2, rv); chk("R8 full period after release", rv, 16'd10);
    wait_edges(1);
    peek(2'd2, rv); chk("R8 counting after release", rv, 16'd9);
    bus_write(2'd0, 16'h0000);

    // R8 break ignored when bit 7 is 0
    dbg_break = 1'b1;
    bus_write(2'd0, 16'h0003);
    wait_edges(4);
    peek(2'd2, rv); chk("R8 break ignored", rv, 16'd9);
    dbg_break = 1'b0;
    bus_write(2'd0, 16'h0000);

    finish_run();
  end
endmodule